// File: doc/BRIEF.md
# Reserved Frame Type Receive Filter

This block sits at the end of an IEEE 802.15.4 style receive path and makes one verdict per received frame. When the receiver strobes end-of-frame, the block looks at the 3-bit frame type, the FCS result, the result of an upstream address matcher and the acknowledge-request flag. One clock later it emits single-cycle pulses for frame-end, address-match and send-acknowledge, or a drop pulse when the frame is not passed on.

Frame types 0 to 3 (beacon, data, acknowledge, MAC command) always follow the compliant data path. Types 4 to 7 are reserved. A two-bit policy in a small control register decides their fate. With the upload bit clear they are blocked. With upload set and filter clear they are passed after an FCS check only. With both set they are filtered exactly like data frames.

The control register sits at address 0x17 of a simple write-enable/address/data bus, with a combinational read port. It also holds three general read/write mode bits (6, 2, 1), which this block stores but does not use.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset the control register reads 0x00 and all four outputs are 0.
- R2: A write to address 0x17 updates only bits 6, 5 (filter-reserved), 4 (upload-reserved), 2 and 1. Bits 7, 3 and 0 always read 0. Writes to any other address leave the register unchanged, and reads of any other address return 0.
- R3: A frame type value of 4 to 7 is reserved. Values 0 to 3 are never treated as reserved, whatever the policy bits hold.
- R4: With the upload-reserved bit at 0, a reserved frame produces only a drop pulse, even when the filter-reserved bit is 1.
- R5: With upload at 1 and filter at 0, a reserved frame with a correct FCS produces frame-end only. Address-match and send-acknowledge stay 0 whatever the address and request inputs are.
- R6: With upload and filter both at 1, a reserved frame gives the same outputs as a data frame with identical inputs.
- R7: A frame with a bad FCS produces only a drop pulse, under every policy and type.
- R8: On the data path (non-reserved frames, or reserved frames in filter mode) with a correct FCS, the block raises frame-end. It raises address-match when the address matches. It raises send-acknowledge only when the address matches and the request bit is set.
- R9: Each output pulse appears in the cycle after the end-of-frame strobe and lasts one cycle. No output pulses without a strobe. Exactly one of frame-end and drop pulses per strobe.
- R10: When a register write and an end-of-frame strobe fall in the same cycle, the verdict uses the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_waddr | input | ADDR_W (8) | Write address |
| cfg_wdata | input | DATA_W (8) | Write data |
| cfg_raddr | input | ADDR_W (8) | Read address |
| cfg_rdata | output | DATA_W (8) | Read data, combinational |
| rx_end | input | 1 | One-cycle end-of-frame strobe |
| rx_ftype | input | 3 | Frame type field (frame control bits 2:0) |
| rx_fcs_ok | input | 1 | FCS check passed |
| rx_addr_hit | input | 1 | Address matcher result |
| rx_ack_req | input | 1 | Acknowledge-request flag of the frame |
| frame_done_o | output | 1 | Frame-end pulse |
| addr_match_o | output | 1 | Address-match pulse |
| ack_send_o | output | 1 | Send-acknowledge pulse |
| drop_o | output | 1 | Frame dropped pulse |

## Verification
A policy write and a frame verdict can land in the same clock cycle. This is the one place where the ordering of two functions decides the result. The bench provokes it directly: it switches from blocked to upload mode in the very cycle a reserved frame ends, and it does the same for the reverse change. It also mixes random writes into random frame strobes. Each verdict is judged against a bench model that reads a shadow register updated only after the verdict is computed.

// File: rtl/rfg_pkg.sv
package rfg_pkg;

   // how a reserved-type frame is to be handled
   typedef enum logic [1:0] {
      POL_BLOCK   = 2'd0,
      POL_UPLOAD  = 2'd1,
      POL_AS_DATA = 2'd2
   } rsv_policy_e;

   // one verdict per frame
   typedef struct packed {
      logic done;
      logic amatch;
      logic ack;
      logic drop;
   } rx_verdict_t;

endpackage

// File: rtl/rfg_ctrl_reg.sv
module rfg_ctrl_reg #(
   parameter int unsigned          ADDR_W   = 8,
   parameter int unsigned          DATA_W   = 8,
   parameter logic [ADDR_W-1:0]    REG_ADDR = 8'h17,
   parameter logic [DATA_W-1:0]    WR_MASK  = 8'b0111_0110,
   parameter int unsigned          FILT_BIT = 5,
   parameter int unsigned          UPLD_BIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              upld_en,
   output logic              filt_en
);

   localparam logic [DATA_W-1:0] KEEP_MASK = ~WR_MASK;

   if (FILT_BIT >= DATA_W || UPLD_BIT >= DATA_W) begin : g_bad_pos
      $error("rfg_ctrl_reg: policy bit outside register");
   end
   if (FILT_BIT == UPLD_BIT) begin : g_bad_same
      $error("rfg_ctrl_reg: policy bits must differ");
   end
   if (!WR_MASK[FILT_BIT] || !WR_MASK[UPLD_BIT]) begin : g_bad_mask
      $error("rfg_ctrl_reg: policy bits must be writable");
   end

   logic [DATA_W-1:0] ctl_q;
   logic              hit_w;

   assign hit_w = we && (waddr == REG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (hit_w) begin
         ctl_q <= (ctl_q & KEEP_MASK) | (wdata & WR_MASK);
      end
   end

   always_comb begin
      rdata = '0;
      if (raddr == REG_ADDR) begin
         rdata = ctl_q;
      end
   end

   assign upld_en = ctl_q[UPLD_BIT];
   assign filt_en = ctl_q[FILT_BIT];

   // R2
   foreign_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr != REG_ADDR) |=> $stable(ctl_q));

   // R2
   wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_w |=> ((ctl_q & WR_MASK) == ($past(wdata) & WR_MASK)));

endmodule

// File: rtl/rfg_classify.sv
module rfg_classify
   import rfg_pkg::*;
#(
   parameter int unsigned TYPE_W    = 3,
   parameter int unsigned RSV_FIRST = 4
) (
   input  logic [TYPE_W-1:0] ftype,
   input  logic              upld_en,
   input  logic              filt_en,
   output logic              is_rsv,
   output rsv_policy_e       policy
);

   localparam int unsigned           TYPE_N   = 1 << TYPE_W;
   localparam logic [TYPE_W-1:0]     RSV_CODE = TYPE_W'(RSV_FIRST);
   localparam bit                    MSB_FORM = (RSV_FIRST == TYPE_N / 2);

   if (RSV_FIRST == 0 || RSV_FIRST >= TYPE_N) begin : g_bad_rsv
      $error("rfg_classify: reserved range must be non-empty and partial");
   end

   if (MSB_FORM) begin : g_msb
      // reserved range is exactly the upper half: a single bit decides
      assign is_rsv = ftype[TYPE_W-1];
   end else begin : g_cmp
      assign is_rsv = (ftype >= RSV_CODE);
   end

   // filter bit has no meaning unless upload is set
   always_comb begin
      if (!upld_en) begin
         policy = POL_BLOCK;
      end else if (filt_en) begin
         policy = POL_AS_DATA;
      end else begin
         policy = POL_UPLOAD;
      end
   end

endmodule

// File: rtl/rfg_decide.sv
module rfg_decide
   import rfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_end,
   input  logic        is_rsv,
   input  rsv_policy_e policy,
   input  logic        fcs_ok,
   input  logic        addr_hit,
   input  logic        ack_req,
   output rx_verdict_t verdict_q
);

   rx_verdict_t nxt;
   logic        data_path;
   logic        pass;

   always_comb begin
      data_path = !is_rsv || (policy == POL_AS_DATA);
      pass      = fcs_ok && (data_path || (policy == POL_UPLOAD));
      nxt       = '0;
      if (rx_end) begin
         nxt.done   = pass;
         nxt.amatch = pass && data_path && addr_hit;
         nxt.ack    = pass && data_path && addr_hit && ack_req;
         nxt.drop   = !pass;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         verdict_q <= '0;
      end else begin
         verdict_q <= nxt;
      end
   end

   // R9
   pulse_needs_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_q.done || verdict_q.drop) |-> $past(rx_end));

   // R9
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end |=> $onehot({verdict_q.done, verdict_q.drop}));

   // R7
   bad_fcs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && !fcs_ok) |=> (verdict_q.drop && !verdict_q.amatch && !verdict_q.ack));

   // R8
   ack_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_q.ack |-> (verdict_q.amatch && verdict_q.done));

   // R5
   upload_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && is_rsv && policy == POL_UPLOAD) |=> (!verdict_q.amatch && !verdict_q.ack));

   // R4
   blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && is_rsv && policy == POL_BLOCK) |=> verdict_q.drop);

endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
   import rfg_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h17,
   parameter logic [DATA_W-1:0] WR_MASK   = 8'b0111_0110,
   parameter int unsigned       FILT_BIT  = 5,
   parameter int unsigned       UPLD_BIT  = 4,
   parameter int unsigned       TYPE_W    = 3,
   parameter int unsigned       RSV_FIRST = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_waddr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [ADDR_W-1:0] cfg_raddr,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              rx_end,
   input  logic [TYPE_W-1:0] rx_ftype,
   input  logic              rx_fcs_ok,
   input  logic              rx_addr_hit,
   input  logic              rx_ack_req,
   output logic              frame_done_o,
   output logic              addr_match_o,
   output logic              ack_send_o,
   output logic              drop_o
);

   logic        upld_en;
   logic        filt_en;
   logic        is_rsv;
   rsv_policy_e policy;
   rx_verdict_t verdict;

   rfg_ctrl_reg #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .REG_ADDR (REG_ADDR),
      .WR_MASK  (WR_MASK),
      .FILT_BIT (FILT_BIT),
      .UPLD_BIT (UPLD_BIT)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .waddr   (cfg_waddr),
      .wdata   (cfg_wdata),
      .raddr   (cfg_raddr),
      .rdata   (cfg_rdata),
      .upld_en (upld_en),
      .filt_en (filt_en)
   );

   rfg_classify #(
      .TYPE_W    (TYPE_W),
      .RSV_FIRST (RSV_FIRST)
   ) u_cls (
      .ftype   (rx_ftype),
      .upld_en (upld_en),
      .filt_en (filt_en),
      .is_rsv  (is_rsv),
      .policy  (policy)
   );

   rfg_decide u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_end    (rx_end),
      .is_rsv    (is_rsv),
      .policy    (policy),
      .fcs_ok    (rx_fcs_ok),
      .addr_hit  (rx_addr_hit),
      .ack_req   (rx_ack_req),
      .verdict_q (verdict)
   );

   assign frame_done_o = verdict.done;
   assign addr_match_o = verdict.amatch;
   assign ack_send_o   = verdict.ack;
   assign drop_o       = verdict.drop;

   // R10
   old_policy_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_end && rx_ftype >= TYPE_W'(RSV_FIRST) && rx_fcs_ok && !upld_en) |=> drop_o);

endmodule

// File: tb/sim_rx_frame_gate.sv
`timescale 1ns/1ps
module sim_rx_frame_gate;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_waddr = 8'h00;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_raddr = 8'h17;
   logic [7:0] cfg_rdata;
   logic       rx_end = 1'b0;
   logic [2:0] rx_ftype = 3'd0;
   logic       rx_fcs_ok = 1'b0;
   logic       rx_addr_hit = 1'b0;
   logic       rx_ack_req = 1'b0;
   logic       frame_done_o, addr_match_o, ack_send_o, drop_o;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;
   logic [7:0] shadow = 8'h00;

   always #4 clk = ~clk;

   rx_frame_gate u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
      .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
      .rx_end(rx_end), .rx_ftype(rx_ftype), .rx_fcs_ok(rx_fcs_ok),
      .rx_addr_hit(rx_addr_hit), .rx_ack_req(rx_ack_req),
      .frame_done_o(frame_done_o), .addr_match_o(addr_match_o),
      .ack_send_o(ack_send_o), .drop_o(drop_o)
   );

   // expected {done, amatch, ack, drop} from the requirements
   function automatic logic [3:0] model(input logic [7:0] reg_v, input logic [2:0] ft,
                                        input logic fcs, input logic hit, input logic req);
      logic rsv, up, fl, dpath, pass;
      rsv   = (ft >= 3'd4);             // R3
      up    = reg_v[4];
      fl    = reg_v[5];
      dpath = !rsv || (up && fl);       // R6
      pass  = fcs && (dpath || up);     // R4 R5 R7
      return {pass, pass && dpath && hit, pass && dpath && hit && req, !pass};
   endfunction

   function automatic logic [7:0] reg_after(input logic [7:0] old, input logic [7:0] wd);
      return (old & 8'b1000_1001) | (wd & 8'b0111_0110);
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a == 8'h17) shadow = reg_after(shadow, d);
   endtask

   // one frame, optionally with a write in the same cycle
   task automatic frame(input logic [2:0] ft, input logic fcs, input logic hit,
                        input logic req, input logic do_wr, input logic [7:0] wd,
                        input string tag);
      logic [3:0] exp;
      @(negedge clk);
      rx_end = 1'b1; rx_ftype = ft; rx_fcs_ok = fcs;
      rx_addr_hit = hit; rx_ack_req = req;
      cfg_we = do_wr; cfg_waddr = 8'h17; cfg_wdata = wd;
      exp = model(shadow, ft, fcs, hit, req);      // R10 uses pre-write value
      @(negedge clk);
      rx_end = 1'b0; cfg_we = 1'b0;
      rx_addr_hit = ~hit; rx_ack_req = ~req;
      if (do_wr) shadow = reg_after(shadow, wd);
      chk({4'h0, frame_done_o, addr_match_o, ack_send_o, drop_o}, {4'h0, exp}, tag);
      @(negedge clk);
      // R9 single-cycle pulses, none without a strobe
      chk({4'h0, frame_done_o, addr_match_o, ack_send_o, drop_o}, 8'h00, "R9 idle");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      process::self().srandom(32'd1717);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cfg_rdata, 8'h00, "R1 reg reset");
      chk({4'h0, frame_done_o, addr_match_o, ack_send_o, drop_o}, 8'h00, "R1 outputs reset");
      rst_n = 1'b1;

      // R2 mask and address decode
      wr(8'h17, 8'hFF);
      chk(cfg_rdata, 8'h76, "R2 writable bits");
      wr(8'h16, 8'h00);
      chk(cfg_rdata, 8'h76, "R2 foreign write");
      cfg_raddr = 8'h18; #1;
      chk(cfg_rdata, 8'h00, "R2 foreign read");
      cfg_raddr = 8'h17;
      wr(8'h17, 8'h89);
      chk(cfg_rdata, 8'h00, "R2 reserved bits");

      // R4 blocked, also with filter alone
      frame(3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 blocked");
      wr(8'h17, 8'h20);
      frame(3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R4 filter without upload");
      // R3 non-reserved types unaffected by block
      frame(3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R3 command type");
      frame(3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R8 no ack request");
      // R5 upload only
      wr(8'h17, 8'h10);
      frame(3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R5 upload only");
      frame(3'd6, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R7 upload bad fcs");
      // R6 filter mode
      wr(8'h17, 8'h30);
      frame(3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R6 as data");
      frame(3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R6 no address");
      frame(3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, "R7 beacon bad fcs");
      // R10 concurrent write and verdict
      wr(8'h17, 8'h00);
      frame(3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 8'h10, "R10 block to upload");
      frame(3'd6, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, "R10 upload to block");
      frame(3'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R10 after write");

      // random mix
      for (int i = 0; i < 500; i++) begin
         frame(3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               ($urandom % 4) == 0, 8'($urandom), "R8 random");
      end

      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule